// File: doc/BRIEF.md
# Cross-Domain Write Busy Tracker

This block sits between a bus clock domain and the core clock domain of a timer/counter. Eight registers are written from the bus side: soft reset, enable, a second control word, status, count, period and two compare/capture values. Each accepted write starts its own crossing. A request toggle crosses through two flops into the core domain and produces a one-cycle load strobe with the written data. The toggle then returns through two more flops. While a crossing is open, the register's busy flag is high. A new write to that register is held off with `bus_ready` low, so no toggle is ever lost.

The period and the two compare/capture values are buffered in the timer. Their busy flags also stay high after the crossing, until the timer signals an update condition or clears that buffer's valid flag. A status write only starts a crossing when it writes a 1 into one of the two capture buffer-valid bits. The live flags appear on `busy_flags` and can also be read at a fixed bus address.

Top module: `xdom_busy_tracker`

## Requirements
- R1: After reset every busy flag is 0. A bus read with `bus_addr` = 8 returns the flags in the same cycle: bit 0 soft reset, bit 1 enable, bit 2 control B, bit 3 status, bit 4 count, bit 5 period, bit 6 compare 0, bit 7 compare 1. Bits 31:8 read as 0.
- R2: An accepted write to address k (0..7) that starts a crossing sets busy bit k from the next bus cycle. A busy bit never rises without such a write.
- R3: For bits 0..4, the busy bit stays high until the core has received the load strobe for that write. It then clears within a few bus cycles once the returned toggle arrives.
- R4: Each started crossing gives exactly one single-cycle `core_load[k]` pulse in the core domain, with the written value on `core_data[k*DW +: DW]`. Successive writes to one register arrive in write order.
- R5: Busy bits 5..7 also stay high after their crossing until `upd_evt` (which clears all three) or their own `bufv_clr` bit (bit 0 period, bit 1 compare 0, bit 2 compare 1).
- R6: A write to address 3 starts a crossing only if `bus_wdata[1:0]` is not zero. Otherwise it sets no flag and gives no core load.
- R7: A write to an address whose busy bit is set is stalled with `bus_ready` low until the bit clears, and is then accepted.
- R8: A write to the busy address 8 changes no flag and produces no core load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | 32 | Read data (busy flags at address 8) |
| bus_ready | output | 1 | Low while a write is stalled |
| busy_flags | output | 8 | Live busy flags |
| upd_evt | input | 1 | Timer update condition, bus domain pulse |
| bufv_clr | input | 3 | Buffer-valid clear pulses: period, compare 0, compare 1 |
| cclk | input | 1 | Core clock |
| crst_n | input | 1 | Core-domain reset, active low |
| core_load | output | 8 | One-cycle load strobe per register, core domain |
| core_data | output | 8*DW | Held value of each register |

## Verification
The assertions assume that `upd_evt` and `bufv_clr` are already synchronous single-cycle pulses in the bus domain. They also assume that both resets are released together, so the toggle pairs start out matched. The stimulus drives every bus-side input on the bus clock's falling edge and raises the update and clear pulses for one bus cycle only. It releases both resets in the same window. The core clock is left free-running at an unrelated period, which lets arrival skew vary between crossings.

// File: rtl/xdom_busy_tracker.sv
module xdom_busy_tracker #(
  parameter int DW        = 16,
  parameter int AW        = 4,
  parameter int BUSY_ADDR = 8
) (
  input  logic                 bclk,
  input  logic                 brst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ready,
  output logic [7:0]           busy_flags,
  input  logic                 upd_evt,
  input  logic [2:0]           bufv_clr,
  input  logic                 cclk,
  input  logic                 crst_n,
  output logic [7:0]           core_load,
  output logic [8*DW-1:0]      core_data
);
  localparam int NREG    = 8;
  localparam int ST_IDX  = 3;
  localparam int PER_IDX = 5;
  localparam int NBUF    = NREG - PER_IDX;
  localparam logic [AW-1:0]   NREG_A = AW'(NREG);
  localparam logic [AW-1:0]   BUSY_A = AW'(BUSY_ADDR);
  localparam logic [NREG-1:0] ST_BIT = NREG'(1) << ST_IDX;

  logic [NREG-1:0] req_t, ak_s1, ak_s2, wsel, start;
  logic [NREG-1:0] rq_s1, rq_s2, rq_s3;
  logic [NBUF-1:0] buf_pend;
  logic [DW-1:0]   shadow [NREG];
  logic            stall, stat_ok;

  // bus side decode and stall
  assign wsel      = (bus_sel && bus_wr && bus_addr < NREG_A) ? (NREG'(1) << bus_addr) : '0;
  assign stall     = |(wsel & busy_flags);
  assign bus_ready = !stall;
  assign stat_ok   = |bus_wdata[1:0];
  assign start     = (stall ? '0 : wsel) & ~(stat_ok ? '0 : ST_BIT);

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      req_t    <= '0;
      ak_s1    <= '0;
      ak_s2    <= '0;
      buf_pend <= '0;
    end else begin
      req_t    <= req_t ^ start;
      ak_s1    <= rq_s3;
      ak_s2    <= ak_s1;
      buf_pend <= (buf_pend & ~(bufv_clr | {NBUF{upd_evt}})) | start[NREG-1:PER_IDX];
    end
  end

  always_ff @(posedge bclk) begin
    for (int i = 0; i < NREG; i++)
      if (start[i]) shadow[i] <= bus_wdata;
  end

  assign busy_flags = (req_t ^ ak_s2) | {buf_pend, {PER_IDX{1'b0}}};
  assign bus_rdata  = (bus_sel && !bus_wr && bus_addr == BUSY_A)
                      ? {{(32-NREG){1'b0}}, busy_flags} : 32'h0;

  // core side: request toggles arrive, third flop is the returned acknowledge
  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      rq_s1 <= '0;
      rq_s2 <= '0;
      rq_s3 <= '0;
    end else begin
      rq_s1 <= req_t;
      rq_s2 <= rq_s1;
      rq_s3 <= rq_s2;
    end
  end

  assign core_load = rq_s2 ^ rq_s3;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign core_data[k*DW +: DW] = shadow[k];

    assert_set_R2: assert property (@(posedge bclk) disable iff (!brst_n)
      (bus_sel && bus_wr && bus_ready && bus_addr == AW'(k) && (k != ST_IDX || |bus_wdata[1:0]))
      |=> busy_flags[k]);

    assert_rise_R2: assert property (@(posedge bclk) disable iff (!brst_n)
      $rose(busy_flags[k]) |-> $past(bus_sel && bus_wr && bus_ready && bus_addr == AW'(k)));

    assert_stall_R7: assert property (@(posedge bclk) disable iff (!brst_n)
      (bus_sel && bus_wr && bus_addr == AW'(k) && busy_flags[k]) |-> !bus_ready);

    assert_pulse_R4: assert property (@(posedge cclk) disable iff (!crst_n)
      core_load[k] |=> !core_load[k]);
  end

  for (genvar j = 0; j < NBUF; j++) begin : g_buf
    assert_hold_R5: assert property (@(posedge bclk) disable iff (!brst_n)
      (buf_pend[j] && !upd_evt && !bufv_clr[j]) |=> busy_flags[PER_IDX + j]);
  end

  assert_status_zero_R6: assert property (@(posedge bclk) disable iff (!brst_n)
    (bus_sel && bus_wr && bus_addr == AW'(ST_IDX) && bus_wdata[1:0] == 2'b00 && !busy_flags[ST_IDX])
    |=> !busy_flags[ST_IDX]);

  assert_busy_write_R8: assert property (@(posedge bclk) disable iff (!brst_n)
    (bus_sel && bus_wr && bus_addr == BUSY_A) |-> bus_ready);
endmodule

// File: tb/xdom_busy_tracker_tb_top.sv
`timescale 1ns/1ps
module xdom_busy_tracker_tb_top;
  localparam int DW = 16;

  logic bclk = 0, cclk = 0, brst_n = 0, crst_n = 0;
  logic bus_sel = 0, bus_wr = 0, upd_evt = 0;
  logic [3:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0;
  logic [2:0] bufv_clr = 0;
  logic [31:0] bus_rdata;
  logic bus_ready;
  logic [7:0] busy_flags, core_load;
  logic [8*DW-1:0] core_data;

  always #10 bclk = ~bclk;
  always #14.5 cclk = ~cclk;

  xdom_busy_tracker #(.DW(DW)) dut_i (
    .bclk(bclk), .brst_n(brst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .busy_flags(busy_flags), .upd_evt(upd_evt),
    .bufv_clr(bufv_clr), .cclk(cclk), .crst_n(crst_n),
    .core_load(core_load), .core_data(core_data));

  int checks = 0, errors = 0;
  logic [DW-1:0] expq [8][$];
  bit [7:0] inflight = 0, delivered = 0, pend = 0;
  int age [8];
  bit acc_v = 0, ev_upd = 0, run = 0;
  logic [3:0] acc_a;
  logic [DW-1:0] acc_d;
  logic [2:0] ev_clr = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model, compared every bus cycle
  always @(negedge bclk) if (run) begin
    if (ev_upd) pend[7:5] = 3'b000;
    for (int j = 0; j < 3; j++) if (ev_clr[j]) pend[5+j] = 0;
    ev_upd = 0; ev_clr = 0;
    if (acc_v && acc_a < 8 && !(acc_a == 3 && acc_d[1:0] == 2'b00)) begin
      inflight[acc_a] = 1; delivered[acc_a] = 0; age[acc_a] = 0;
      if (acc_a >= 5) pend[acc_a] = 1;
      expq[acc_a].push_back(acc_d);
    end
    acc_v = 0;
    for (int k = 0; k < 8; k++) begin
      if (pend[k] || (inflight[k] && !delivered[k]))
        chk(busy_flags[k], k < 5 ? "R3" : "R5", $sformatf("busy[%0d] held", k), busy_flags[k], 1);
      else if (!inflight[k])
        chk(!busy_flags[k], "R2", $sformatf("busy[%0d] idle", k), busy_flags[k], 0);
      else if (!busy_flags[k]) inflight[k] = 0;
      else begin
        age[k]++;
        chk(age[k] <= 8, "R3", $sformatf("busy[%0d] clear latency", k), age[k], 8);
      end
    end
  end

  // core-domain delivery monitor
  always @(negedge cclk) if (run) begin
    for (int k = 0; k < 8; k++) if (core_load[k]) begin
      if (expq[k].size() == 0) chk(0, "R4", $sformatf("unexpected load %0d", k), 1, 0);
      else begin
        logic [DW-1:0] e;
        e = expq[k].pop_front();
        chk(core_data[k*DW +: DW] == e, "R4", $sformatf("load data %0d", k), core_data[k*DW +: DW], e);
      end
      delivered[k] = 1;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d, output int waited);
    waited = 0;
    @(negedge bclk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin @(negedge bclk); #2; waited++; end
    acc_v = 1; acc_a = a; acc_d = d;
    @(posedge bclk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pulse(input bit u, input logic [2:0] c);
    @(negedge bclk); #1;
    upd_evt = u; bufv_clr = c; ev_upd = u; ev_clr = c;
    @(posedge bclk); #1;
    upd_evt = 0; bufv_clr = 0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge bclk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = 4'd8;
    #1 v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bclk);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w;
    logic [31:0] v;
    repeat (5) @(negedge bclk);
    brst_n = 1; crst_n = 1;
    #1 chk(busy_flags == 8'h00, "R1", "reset flags", busy_flags, 0);
    run = 1;
    rd(v); chk(v == 32'h0, "R1", "reset read", v, 0);

    // plain registers, distinct data
    for (int k = 0; k < 5; k++) begin
      wr(k[3:0], DW'(16'hA100 + k * 16'h0111 + 16'h1), w);
      idle(12);
    end
    wr(4'd2, 16'h5A5A, w);
    rd(v); chk(v == 32'h0000_0004, "R1", "read while control B busy", v, 32'h4);
    idle(12);

    // period buffered until update
    wr(4'd5, 16'h1234, w);
    idle(20);
    chk(busy_flags[5], "R5", "period held after crossing", busy_flags[5], 1);
    pulse(1, 3'b000); idle(2);
    chk(!busy_flags[5], "R5", "period cleared by update", busy_flags[5], 0);

    // compare channels, selective buffer-valid clear
    wr(4'd6, 16'h0C0C, w);
    wr(4'd7, 16'h0D0D, w);
    idle(15);
    pulse(0, 3'b010); idle(2);
    chk(!busy_flags[6] && busy_flags[7], "R5", "compare 0 cleared alone", busy_flags[7:6], 2'b10);
    pulse(0, 3'b100); idle(2);
    chk(busy_flags[7:5] == 3'b000, "R5", "compare 1 cleared", busy_flags[7:5], 0);

    // status needs a 1 in a buffer-valid bit
    wr(4'd3, 16'hFFFC, w); idle(1);
    chk(!busy_flags[3], "R6", "status zero write ignored", busy_flags[3], 0);
    idle(10);
    wr(4'd3, 16'h0002, w); idle(1);
    chk(busy_flags[3], "R6", "status write starts crossing", busy_flags[3], 1);
    idle(12);

    // back-to-back writes stall and stay in order
    wr(4'd1, 16'h1111, w);
    wr(4'd1, 16'h2222, w);
    chk(w > 0, "R7", "second enable write stalled", w, 1);
    wr(4'd1, 16'h3333, w);
    chk(w > 0, "R7", "third enable write stalled", w, 1);
    idle(12);

    // buffered stall released by update
    wr(4'd5, 16'hBEEF, w);
    fork
      wr(4'd5, 16'hCAFE, w);
      begin idle(16); pulse(1, 3'b000); end
    join
    chk(w >= 15, "R7", "period write held until update", w, 15);
    idle(15);
    pulse(1, 3'b000);
    idle(4);

    // write to the busy address
    wr(4'd8, 16'hFFFF, w); idle(6);
    chk(busy_flags == 8'h00, "R8", "busy write ignored", busy_flags, 0);

    idle(20);
    for (int k = 0; k < 8; k++)
      chk(expq[k].size() == 0, "R4", $sformatf("queue %0d drained", k), expq[k].size(), 0);
    chk(busy_flags == 8'h00, "R3", "all flags idle at end", busy_flags, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule